// File: doc/BRIEF.md
# Bidirectional LCD Gate Scan Sequencer

This block drives the row-select lines of a display gate driver at logic level. The outputs are numbered 0 to N_OUT-1, with 240 by default. On every rising edge of the vertical shift clock it samples an active-low start request. When it sees a new start, it sends a select token across the rows. The token runs in ascending or descending output order, as the direction input selects. A two-bit pattern input picks one of four patterns: a single selected row, a pair of neighbouring rows, a pair of rows two apart, or all rows off.

Two chips can share one panel and one start line. Each chip works out from its direction and position inputs whether it scans first or second. A first chip starts its token at once. A second chip counts N_OUT shift clocks on its own before its token appears. No carry signal passes between the two chips.

Top module: `gate_scan_seq`

## Requirements
- R1: The row vector is N_OUT bits wide, 240 by default. With `dir_fwd`=1 the scan visits output 0 first and output N_OUT-1 last.
- R2: With `dir_fwd`=0 the scan visits output N_OUT-1 first and output 0 last.
- R3: A start is taken at the first clock edge where `start_n` is sampled low after being sampled high (its reset value counts as high). Its rows appear right after that edge. Holding `start_n` low on later edges does not start the scan again.
- R4: `mode`=2'b11 gives single-row scanning. The scan position p counts clock edges since the start, beginning at 0. The logical row p is selected, and at most one output is high on any cycle.
- R5: `mode`=2'b01 gives the adjacent-pair pattern. Logical rows p and p-1 are selected when they lie inside 0..N_OUT-1. No more than two outputs are ever high.
- R6: `mode`=2'b10 gives the spaced-pair pattern. Logical rows p and p-2 are selected when they lie inside 0..N_OUT-1. No more than two outputs are ever high.
- R7: `mode`=2'b00 holds every output low, whatever the scan state.
- R8: The chip scans first when `pos_en` equals `dir_fwd`, and second otherwise.
- R9: A second chip uses p = k - N_OUT, where k counts edges since the start edge. As a result, its first row appears exactly N_OUT clocks after the row a first chip would show.
- R10: After the token has left the last row, all outputs stay low until the next start. A new start in the middle of a scan restarts the scan from position 0.
- R11: While `rst_n` is low, all outputs are low at once. After reset, nothing is selected until a new start arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Vertical shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low scan start request |
| dir_fwd | input | 1 | 1: ascending output order, 0: descending |
| pos_en | input | 1 | Cascade position select, read together with dir_fwd |
| mode | input | 2 | Pulse pattern: 11 single, 01 adjacent pair, 10 spaced pair, 00 all off |
| rowsel | output | N_OUT | Logic-level row-select vector, 1 = selected |

## Verification
The checker assertions run on every cycle. They check that the all-off pattern blanks the outputs and that the single-row pattern never selects more than one row. They check that both pair patterns stay at two rows or fewer, and that nothing is selected while the scan is idle. They also check that a start loads position zero and that the position then steps by exactly one per clock. The bench scenarios are the only checks of where the token actually lands. These include the ascending and descending order, the N_OUT-clock delay of a second chip, and the exact pair spacing, including the single-row ends of the pair patterns. The bench also shows that a held start does not start the scan again, that a restart in mid-scan works, and that reset during a scan clears the outputs.

// File: rtl/gss_pkg.sv
package gss_pkg;

  typedef enum logic [1:0] {
    PAT_OFF    = 2'b00,
    PAT_ADJ    = 2'b01,
    PAT_SPACED = 2'b10,
    PAT_SINGLE = 2'b11
  } pat_e;

  // Distance between the leading row and the trailing row of the active window.
  function automatic int unsigned trail_gap(pat_e p);
    case (p)
      PAT_ADJ:    return 1;
      PAT_SPACED: return 2;
      default:    return 0;
    endcase
  endfunction

  // The chip leads the cascade when both position inputs agree.
  function automatic logic leads_cascade(logic fwd, logic pos);
    return fwd == pos;
  endfunction

endpackage

// File: rtl/gss_start_detect.sv
module gss_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic start_evt
);
  logic seen_high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_high_q <= 1'b1;
    else        seen_high_q <= start_n;
  end

  // A start is a low sample after a high one.
  assign start_evt = seen_high_q & ~start_n;
endmodule

// File: rtl/gss_scan_counter.sv
module gss_scan_counter #(
  parameter int N_OUT = 240,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  output logic          scan_active,
  output logic [CW-1:0] scan_cnt
);
  // The final position covers a second chip's spaced pair on its last row.
  localparam int LAST = 2 * N_OUT + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_active <= 1'b0;
      scan_cnt    <= '0;
    end else if (start_evt) begin
      scan_active <= 1'b1;
      scan_cnt    <= '0;
    end else if (scan_active) begin
      if (scan_cnt == CW'(LAST)) scan_active <= 1'b0;
      else                       scan_cnt    <= scan_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gss_row_decode.sv
module gss_row_decode
  import gss_pkg::*;
#(
  parameter int N_OUT = 240,
  parameter int CW    = 10
) (
  input  logic             scan_active,
  input  logic [CW-1:0]    scan_cnt,
  input  logic             dir_fwd,
  input  logic             role_first,
  input  pat_e             pat,
  output logic [N_OUT-1:0] rows
);
  // A row is hit when the position equals its base, or its base plus the trail gap.
  function automatic logic row_hit(logic [CW-1:0] c, logic [CW-1:0] b, pat_e p);
    logic lead, trail;
    lead  = (c == b);
    trail = (c == b + CW'(trail_gap(p)));
    case (p)
      PAT_SINGLE:         return lead;
      PAT_ADJ, PAT_SPACED: return lead | trail;
      default:            return 1'b0;
    endcase
  endfunction

  logic [CW-1:0] delay_ofs;
  assign delay_ofs = role_first ? '0 : CW'(N_OUT);

  for (genvar i = 0; i < N_OUT; i++) begin : g_row
    logic [CW-1:0] base_i;
    assign base_i  = (dir_fwd ? CW'(i) : CW'(N_OUT - 1 - i)) + delay_ofs;
    assign rows[i] = scan_active & row_hit(scan_cnt, base_i, pat);
  end
endmodule

// File: rtl/gate_scan_seq.sv
module gate_scan_seq
  import gss_pkg::*;
#(
  parameter int N_OUT = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             dir_fwd,
  input  logic             pos_en,
  input  logic [1:0]       mode,
  output logic [N_OUT-1:0] rowsel
);
  localparam int CW = $clog2(2 * N_OUT + 2) + 1;

  logic          start_evt;
  logic          role_first;
  logic          scan_active;
  logic [CW-1:0] scan_cnt;
  pat_e          pat;

  assign role_first = leads_cascade(dir_fwd, pos_en);
  assign pat        = pat_e'(mode);

  gss_start_detect u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_n   (start_n),
    .start_evt (start_evt)
  );

  gss_scan_counter #(.N_OUT(N_OUT), .CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .scan_active (scan_active),
    .scan_cnt    (scan_cnt)
  );

  gss_row_decode #(.N_OUT(N_OUT), .CW(CW)) u_dec (
    .scan_active (scan_active),
    .scan_cnt    (scan_cnt),
    .dir_fwd     (dir_fwd),
    .role_first  (role_first),
    .pat         (pat),
    .rows        (rowsel)
  );
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
  parameter int N_OUT = 240,
  parameter int CW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             start_evt,
  input logic             scan_active,
  input logic [CW-1:0]    scan_cnt,
  input logic [N_OUT-1:0] rowsel
);
  localparam int LAST = 2 * N_OUT + 1;

  assert_off_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> rowsel == '0);

  assert_single_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> $onehot0(rowsel));

  assert_adj_pair_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> $countones(rowsel) <= 2);

  assert_spaced_pair_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> $countones(rowsel) <= 2);

  assert_idle_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_active |-> rowsel == '0);

  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> scan_active && scan_cnt == '0);

  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active && !start_evt && scan_cnt != CW'(LAST) |=> scan_cnt == $past(scan_cnt) + 1'b1);
endmodule

bind gate_scan_seq gss_checker #(.N_OUT(N_OUT), .CW(CW)) u_gss_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .start_evt   (start_evt),
  .scan_active (scan_active),
  .scan_cnt    (scan_cnt),
  .rowsel      (rowsel)
);

// File: tb/gate_scan_seq_bench.sv
module gate_scan_seq_bench;
  localparam int N = 240;
  localparam time CLK_T = 10ns;
  localparam int KMAX = 2 * N + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic dir_fwd = 1'b1;
  logic pos_en = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [N-1:0] rowsel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_T / 2) clk = ~clk;

  gate_scan_seq #(.N_OUT(N)) u_gate_scan_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .dir_fwd(dir_fwd),
    .pos_en(pos_en), .mode(mode), .rowsel(rowsel)
  );

  // Expected vector k edges after the start edge, built from the requirement text.
  function automatic logic [N-1:0] expect_rows(int k, bit fwd, bit pos, logic [1:0] md);
    logic [N-1:0] v = '0;
    int p = (fwd == pos) ? k : k - N;
    for (int r = 0; r < N; r++) begin
      bit on = 0;
      if (md == 2'b11) on = (r == p);
      if (md == 2'b01) on = (r == p) || (r == p - 1);
      if (md == 2'b10) on = (r == p) || (r == p - 2);
      if (on) v[fwd ? r : N - 1 - r] = 1'b1;
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Full scan compared on every cycle; start held low for hold cycles.
  task automatic run_scan(bit fwd, bit pos, logic [1:0] md, int hold, string req);
    int bad = 0;
    logic [N-1:0] a_bad = '0, e_bad = '0;
    @(negedge clk);
    dir_fwd = fwd; pos_en = pos; mode = md; start_n = 1'b0;
    @(posedge clk);
    for (int k = 0; k <= KMAX; k++) begin
      @(negedge clk);
      if (k + 1 >= hold) start_n = 1'b1;
      if (rowsel !== expect_rows(k, fwd, pos, md)) begin
        if (bad == 0) begin a_bad = rowsel; e_bad = expect_rows(k, fwd, pos, md); end
        bad++;
      end
    end
    check(bad == 0, req, "whole scan", a_bad, e_bad);
  endtask

  task automatic t_reset();
    logic [N-1:0] z = '0;
    check(rowsel === z, "R11", "during reset", rowsel, z);
    check($bits(rowsel) == 240, "R1", "default width", rowsel, z);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rowsel === z, "R11", "idle after reset", rowsel, z);
  endtask

  task automatic t_first_edges();
    logic [N-1:0] e;
    @(negedge clk); dir_fwd = 1; pos_en = 1; mode = 2'b11; start_n = 0;
    @(negedge clk); start_n = 1;
    e = '0; e[0] = 1'b1;
    check(rowsel === e, "R1", "forward first row", rowsel, e);
    repeat (2 * N + 4) @(negedge clk);
    @(negedge clk); dir_fwd = 0; pos_en = 0; start_n = 0;
    @(negedge clk); start_n = 1;
    e = '0; e[N-1] = 1'b1;
    check(rowsel === e, "R2", "reverse first row", rowsel, e);
    repeat (2 * N + 4) @(negedge clk);
  endtask

  task automatic t_second_delay();
    logic [N-1:0] e = '0;
    @(negedge clk); dir_fwd = 1; pos_en = 0; mode = 2'b11; start_n = 0;
    @(negedge clk); start_n = 1;
    repeat (N - 1) @(negedge clk);
    check(rowsel === e, "R9", "second chip silent at k=N-1", rowsel, e);
    @(negedge clk);
    e[0] = 1'b1;
    check(rowsel === e, "R9", "second chip first row at k=N", rowsel, e);
    repeat (N + 4) @(negedge clk);
  endtask

  task automatic t_restart();
    int bad = 0;
    logic [N-1:0] a_bad = '0, e_bad = '0;
    @(negedge clk); dir_fwd = 1; pos_en = 1; mode = 2'b01; start_n = 0;
    @(negedge clk); start_n = 1;
    repeat (50) @(negedge clk);
    start_n = 0;
    @(posedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      start_n = 1;
      if (rowsel !== expect_rows(k, 1, 1, 2'b01) && bad++ == 0) begin
        a_bad = rowsel; e_bad = expect_rows(k, 1, 1, 2'b01);
      end
    end
    check(bad == 0, "R10", "restart mid-scan", a_bad, e_bad);
    repeat (2 * N) @(negedge clk);
  endtask

  task automatic t_reset_mid();
    logic [N-1:0] z = '0;
    @(negedge clk); dir_fwd = 1; pos_en = 1; mode = 2'b11; start_n = 0;
    @(negedge clk); start_n = 1;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rowsel === z, "R11", "async clear mid-scan", rowsel, z);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(rowsel === z, "R11", "no resume after reset", rowsel, z);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_first_edges();
    run_scan(1, 1, 2'b11, 1, "R4 R8 R10");
    run_scan(0, 0, 2'b11, 1, "R2");
    run_scan(1, 0, 2'b11, 1, "R9");
    run_scan(1, 1, 2'b01, 1, "R5");
    run_scan(0, 1, 2'b10, 1, "R6 R9");
    run_scan(0, 0, 2'b10, 1, "R6");
    run_scan(1, 1, 2'b00, 1, "R7");
    run_scan(1, 1, 2'b11, 6, "R3 held start");
    t_second_delay();
    t_restart();
    t_reset_mid();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule